// File: doc/BRIEF.md
# Accumulator Store Shifter

This block prepares one 16-bit half of a 32-bit accumulator for a write to data memory. The half is scaled on the way out by a left shift of zero to seven places. A request strobe samples the accumulator, a half select and a 3-bit shift amount. One clock later the block presents the shifted word with a single-cycle valid flag. The accumulator itself is only read and never altered. The memory write that consumes the word lies outside the block.

The two halves fill the vacated positions differently. When the upper half is stored, its lowest bits take the bits that the shift brings up from the top of the lower half, and the upper bits that leave the word are discarded. When the lower half is stored, zeros enter from the bottom. Between requests the output word holds its last value, whatever the accumulator input does.

Top module: `acc_store_shifter`

## Requirements
- R1: While `rst_i` is high, at every rising clock edge `word_vld_o` becomes 0 and `word_o` becomes 0.
- R2: `word_vld_o` is 1 in exactly the cycle after a cycle in which `req_i` was sampled high, and 0 after any cycle in which `req_i` was low.
- R3: With `half_hi_i` = 1, the word presented after a request equals bits 31..16 of the 32-bit value (`acc_i` shifted left by `shamt_i` places, truncated to 32 bits). Its low bits therefore come from the top of the lower half.
- R4: With `half_hi_i` = 0, the word presented after a request equals `acc_i[15:0]` shifted left by `shamt_i` places and truncated to 16 bits. The lowest `shamt_i` bits are 0.
- R5: A shift amount of 0 presents the selected half exactly as it was: `acc_i[31:16]` for the upper half, `acc_i[15:0]` for the lower half.
- R6: In a cycle after one with `req_i` low, `word_o` keeps its previous value, even if `acc_i`, `half_hi_i` or `shamt_i` change.
- R7: With `acc_i` = 0xFF234567 and `shamt_i` = 7, the lower half gives 0xB380 and the upper half gives 0x91A2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous reset, active high |
| req_i | input | 1 | Store request strobe, sampled at the clock edge |
| half_hi_i | input | 1 | Half select: 1 = upper half, 0 = lower half |
| shamt_i | input | 3 | Left shift amount, 0 to 7 |
| acc_i | input | 32 | Accumulator value (read only) |
| word_o | output | 16 | Shifted half, registered |
| word_vld_o | output | 1 | One-cycle pulse marking a new `word_o` |

## Verification
Every shift amount from 0 to 7 is applied with both half selects to each accumulator pattern. The patterns are all-zeros, all-ones, lone sign bits at bit 31 and bit 15, a run of ones that crosses the half boundary, alternating bits, the worked example and a series of pseudo-random values. The boundary-crossing and bit-15 patterns tell apart the upper-half fill taken from the lower half and a plain zero fill. The all-ones pattern shows whether the lower half zero-fills at its bottom. After every request the inputs are scrambled during an idle cycle, which shows whether the output register holds its value and whether the valid flag stays low.

// File: rtl/stsh_pkg.sv
package stsh_pkg;

    localparam int ACC_W_DEFAULT = 32;
    localparam int SH_W_DEFAULT  = 3;

    typedef enum logic {
        HALF_LOW  = 1'b0,
        HALF_HIGH = 1'b1
    } half_sel_e;

    // Number of distinct shift amounts for a given count width.
    function automatic int shift_choices(input int sh_w);
        return 1 << sh_w;
    endfunction

endpackage

// File: rtl/stsh_half_mux.sv
module stsh_half_mux #(
    parameter int ACC_W = stsh_pkg::ACC_W_DEFAULT,
    parameter int SH_W  = stsh_pkg::SH_W_DEFAULT
) (
    input  logic [ACC_W-1:0]      acc_i,
    input  stsh_pkg::half_sel_e   half_i,
    input  logic [SH_W-1:0]       shamt_i,
    output logic [ACC_W/2-1:0]    word_o
);
    localparam int HALF_W = ACC_W / 2;
    localparam int N_SH   = stsh_pkg::shift_choices(SH_W);

    logic [HALF_W-1:0] cand_hi [N_SH];
    logic [HALF_W-1:0] cand_lo [N_SH];

    // One fixed-distance shifter per amount; the count only steers a mux.
    for (genvar k = 0; k < N_SH; k++) begin : g_amt
        logic [ACC_W-1:0]  full_sh;
        logic [HALF_W-1:0] low_sh;
        assign full_sh    = acc_i << k;
        assign low_sh     = acc_i[HALF_W-1:0] << k;
        assign cand_hi[k] = full_sh[ACC_W-1:HALF_W];
        assign cand_lo[k] = low_sh;
    end

    always_comb begin
        if (half_i == stsh_pkg::HALF_HIGH)
            word_o = cand_hi[shamt_i];
        else
            word_o = cand_lo[shamt_i];
    end
endmodule

// File: rtl/stsh_out_reg.sv
module stsh_out_reg #(
    parameter int W = 16
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         load_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o,
    output logic         vld_o
);
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            q_o   <= '0;
            vld_o <= 1'b0;
        end else begin
            vld_o <= load_i;
            if (load_i)
                q_o <= d_i;
        end
    end
endmodule

// File: rtl/acc_store_shifter.sv
module acc_store_shifter #(
    parameter int ACC_W = stsh_pkg::ACC_W_DEFAULT,
    parameter int SH_W  = stsh_pkg::SH_W_DEFAULT
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               req_i,
    input  logic               half_hi_i,
    input  logic [SH_W-1:0]    shamt_i,
    input  logic [ACC_W-1:0]   acc_i,
    output logic [ACC_W/2-1:0] word_o,
    output logic               word_vld_o
);
    localparam int HALF_W = ACC_W / 2;

    typedef struct packed {
        logic [ACC_W-1:0]    acc;
        stsh_pkg::half_sel_e half;
        logic [SH_W-1:0]     shamt;
    } store_req_t;

    store_req_t        req_s;
    logic [HALF_W-1:0] shifted;

    always_comb begin
        req_s.acc   = acc_i;
        req_s.half  = stsh_pkg::half_sel_e'(half_hi_i);
        req_s.shamt = shamt_i;
    end

    stsh_half_mux #(.ACC_W(ACC_W), .SH_W(SH_W)) mux_i (
        .acc_i   (req_s.acc),
        .half_i  (req_s.half),
        .shamt_i (req_s.shamt),
        .word_o  (shifted)
    );

    stsh_out_reg #(.W(HALF_W)) out_i (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .load_i (req_i),
        .d_i    (shifted),
        .q_o    (word_o),
        .vld_o  (word_vld_o)
    );
endmodule

// File: rtl/stsh_store_checker.sv
module stsh_store_checker #(
    parameter int ACC_W = stsh_pkg::ACC_W_DEFAULT,
    parameter int SH_W  = stsh_pkg::SH_W_DEFAULT
) (
    input logic               clk_i,
    input logic               rst_i,
    input logic               req_i,
    input logic               half_hi_i,
    input logic [SH_W-1:0]    shamt_i,
    input logic [ACC_W-1:0]   acc_i,
    input logic [ACC_W/2-1:0] word_o,
    input logic               word_vld_o
);
    localparam int HALF_W = ACC_W / 2;
    localparam logic [HALF_W-1:0] ONE = HALF_W'(1);

    p_reset_clear_r1: assert property (@(posedge clk_i)
        rst_i |=> (!word_vld_o && word_o == '0));

    p_valid_after_req_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        req_i |=> word_vld_o);

    p_no_valid_idle_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        !req_i |=> !word_vld_o);

    p_low_zero_fill_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (req_i && !half_hi_i) |=>
            ((word_o & ((ONE << $past(shamt_i)) - ONE)) == '0));

    p_high_noshift_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (req_i && half_hi_i && shamt_i == '0) |=>
            (word_o == $past(acc_i[ACC_W-1:HALF_W])));

    p_low_noshift_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (req_i && !half_hi_i && shamt_i == '0) |=>
            (word_o == $past(acc_i[HALF_W-1:0])));

    p_hold_idle_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        !req_i |=> $stable(word_o));
endmodule

bind acc_store_shifter stsh_store_checker #(.ACC_W(ACC_W), .SH_W(SH_W)) chk_i (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .req_i      (req_i),
    .half_hi_i  (half_hi_i),
    .shamt_i    (shamt_i),
    .acc_i      (acc_i),
    .word_o     (word_o),
    .word_vld_o (word_vld_o)
);

// File: tb/acc_store_shifter_tb_top.sv
module acc_store_shifter_tb_top;
    logic        clk_i = 1'b0;
    logic        rst_i = 1'b1;
    logic        req_i = 1'b0;
    logic        half_hi_i = 1'b0;
    logic [2:0]  shamt_i = '0;
    logic [31:0] acc_i = '0;
    logic [15:0] word_o;
    logic        word_vld_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #4 clk_i = ~clk_i;

    acc_store_shifter dut_i (
        .clk_i(clk_i), .rst_i(rst_i), .req_i(req_i), .half_hi_i(half_hi_i),
        .shamt_i(shamt_i), .acc_i(acc_i), .word_o(word_o), .word_vld_o(word_vld_o)
    );

    always @(posedge clk_i) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: actual=%0d cycles expected=<20000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Reference computed by multiplication, scaled by a power of two.
    function automatic logic [15:0] ref_word(input logic [31:0] a, input bit hi, input int n);
        logic [47:0] p;
        if (hi) begin
            p = {16'b0, a} * (48'd1 << n);
            return p[31:16];
        end
        p = {32'b0, a[15:0]} * (48'd1 << n);
        return p[15:0];
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic store(input logic [31:0] a, input bit hi, input int n);
        logic [15:0] exp;
        string tag;
        @(negedge clk_i);
        acc_i = a; half_hi_i = hi; shamt_i = 3'(n); req_i = 1'b1;
        @(negedge clk_i);
        req_i = 1'b0;
        exp = ref_word(a, hi, n);
        if (n == 0) tag = hi ? "R5 R3 high" : "R5 R4 low";
        else if (a == 32'hFF234567 && n == 7) tag = hi ? "R7 R3 high" : "R7 R4 low";
        else tag = hi ? "R3 high" : "R4 low";
        check(tag, {16'b0, word_o}, {16'b0, exp});
        check("R2 valid pulse", {31'b0, word_vld_o}, 32'd1);
        // Idle cycle with scrambled inputs: output must hold, valid low.
        acc_i = ~a ^ 32'h5A5A_C3C3; half_hi_i = ~hi; shamt_i = ~3'(n);
        @(negedge clk_i);
        check("R6 hold", {16'b0, word_o}, {16'b0, exp});
        check("R2 valid idle", {31'b0, word_vld_o}, 32'd0);
    endtask

    initial begin
        logic [31:0] pats [8];
        logic [31:0] lfsr;
        pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF;
        pats[2] = 32'h8000_0000; pats[3] = 32'h0000_8000;
        pats[4] = 32'h0001_FF80; pats[5] = 32'hAAAA_5555;
        pats[6] = 32'hFF23_4567; pats[7] = 32'h1234_5678;

        repeat (3) @(posedge clk_i);
        @(negedge clk_i);
        check("R1 reset valid", {31'b0, word_vld_o}, 32'd0);
        check("R1 reset word", {16'b0, word_o}, 32'd0);
        rst_i = 1'b0;

        for (int p = 0; p < 8; p++)
            for (int n = 0; n < 8; n++)
                for (int h = 0; h < 2; h++)
                    store(pats[p], bit'(h), n);

        lfsr = 32'hC0DE_1234;
        for (int r = 0; r < 24; r++) begin
            lfsr ^= lfsr << 13; lfsr ^= lfsr >> 17; lfsr ^= lfsr << 5;
            for (int n = 0; n < 8; n++)
                for (int h = 0; h < 2; h++)
                    store(lfsr, bit'(h), n);
        end

        // Worked example against fixed constants (R7).
        store(32'hFF23_4567, 1'b0, 7);
        check("R7 low literal", {16'b0, word_o}, 32'h0000_B380);
        store(32'hFF23_4567, 1'b1, 7);
        check("R7 high literal", {16'b0, word_o}, 32'h0000_91A2);

        // Reset mid-run clears the output again (R1).
        @(negedge clk_i);
        rst_i = 1'b1;
        @(negedge clk_i);
        check("R1 reset word again", {16'b0, word_o}, 32'd0);
        check("R1 reset valid again", {31'b0, word_vld_o}, 32'd0);
        rst_i = 1'b0;

        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule